// File: doc/BRIEF.md
# Indirect Page Permission Resolver

This block works out whether a memory access may proceed when a translation entry holds small index fields and not the access rights themselves. One index picks an entry from a programmable base array, which sets the most rights the page can have. A second index picks an entry from an overlay array, which can only take rights away. There are two overlay arrays: one is used by privileged accesses and the other by unprivileged accesses. The result is the intersection of the two entries. It is checked against the requested right (read, write or execute) to give an allow or fault decision.

The request fields are registered once. The decision is then formed combinationally from those registered fields and the current contents of the arrays. Nothing from the overlay is ever cached, so when software rewrites an overlay array word, the effective rights change for every request captured from that clock edge onward. Software loads each array as one 64-bit word through a plain write port.

Top module: `ipr_resolver`

## Requirements
- R1: After reset, every entry of all three arrays is zero, `resp_valid` is 0 and `resp_fault` is 0.
- R2: Each array entry is 4 bits wide: bit 0 grants read, bit 1 grants write, bit 2 grants execute, bit 3 marks the entry usable. Entry i sits at bits [4i+3:4i] of its array's 64-bit word.
- R3: When both selected entries are usable, `resp_perm` is {1, base[2:0] AND overlay[2:0]}. The overlay never adds a right that the base lacks.
- R4: When the base or the overlay entry has bit 3 clear, `resp_perm` is 0 and every access faults.
- R5: A request with `req_priv`=1 uses the privileged overlay array. A request with `req_priv`=0 uses the unprivileged overlay array.
- R6: `req_kind` encodes 0 as read, 1 as write and 2 as execute. `resp_fault` is 1 exactly when the requested right is absent from `resp_perm`.
- R7: `req_kind`=3 is reserved and always faults, whatever the entries grant.
- R8: `cfg_addr` 0 writes the base array, 1 the privileged overlay and 2 the unprivileged overlay. Address 3 changes nothing. A written word governs every request captured on the same edge or later.
- R9: A request is captured on a rising edge. `resp_valid`, `resp_fault` and `resp_perm` show its result until the next edge. With no request captured, `resp_fault` and `resp_perm` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Array word write strobe |
| cfg_addr | input | 2 | Array select: 0 base, 1 privileged overlay, 2 unprivileged overlay |
| cfg_data | input | 64 | Full array word, 16 entries of 4 bits |
| req_valid | input | 1 | Access request present |
| req_base_idx | input | 4 | Index into the base array |
| req_ovl_idx | input | 4 | Index into the selected overlay array |
| req_kind | input | 2 | Requested right: 0 read, 1 write, 2 execute, 3 reserved |
| req_priv | input | 1 | 1 for a privileged access |
| resp_valid | output | 1 | Result present for the captured request |
| resp_fault | output | 1 | Requested right is missing |
| resp_perm | output | 4 | Resolved rights in entry format |

## Verification
The assertions assume that the request and configuration inputs are settled before each rising edge and that `cfg_addr` takes only its decoded values when a write matters. The bench changes every input on the falling edge and reads the outputs on the following falling edge, so each captured value is stable at the edge. The array words use few usable entries, which lets the reserved-kind, unusable-entry and same-edge rewrite cases each hit a known entry.

// File: rtl/ipr_pkg.sv
package ipr_pkg;

   localparam int unsigned ENT_W   = 4;
   localparam int unsigned BIT_RD  = 0;
   localparam int unsigned BIT_WR  = 1;
   localparam int unsigned BIT_EX  = 2;
   localparam int unsigned BIT_USE = 3;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      SEL_BASE   = 2'd0,
      SEL_OVL_PR = 2'd1,
      SEL_OVL_UN = 2'd2,
      SEL_NONE   = 2'd3
   } cfg_sel_e;

endpackage

// File: rtl/ipr_array_reg.sv
module ipr_array_reg #(
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned FIELD_W = 4,
   localparam int unsigned ENTRIES = 1 << IDX_W,
   localparam int unsigned ARR_W   = ENTRIES * FIELD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ARR_W-1:0]   wr_data,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [FIELD_W-1:0] rd_entry
);

   if (IDX_W < 1 || IDX_W > 6) begin : g_bad_idx
      $error("ipr_array_reg: IDX_W out of range");
   end

   logic [ARR_W-1:0]   arr_q;
   logic [FIELD_W-1:0] ent [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) arr_q <= '0;
      else if (wr_en) arr_q <= wr_data;
   end

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      assign ent[i] = arr_q[i*FIELD_W +: FIELD_W];
   end

   assign rd_entry = ent[rd_idx];

   // R8: a written word is what the array holds afterwards
   p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> arr_q == $past(wr_data));

   // R8: without a write strobe the array keeps its contents
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(arr_q));

endmodule

// File: rtl/ipr_combine.sv
module ipr_combine
   import ipr_pkg::*;
#(
   parameter int unsigned FIELD_W = 4
) (
   input  logic               valid_i,
   input  logic [FIELD_W-1:0] base_i,
   input  logic [FIELD_W-1:0] ovl_i,
   input  acc_kind_e          kind_i,
   output logic [FIELD_W-1:0] perm_o,
   output logic               fault_o
);

   if (FIELD_W != ENT_W) begin : g_bad_field
      $error("ipr_combine: FIELD_W must match the entry format");
   end

   localparam int unsigned RW = FIELD_W - 1;

   logic          usable;
   logic [RW-1:0] rights;
   logic [RW-1:0] need;

   assign usable = base_i[BIT_USE] & ovl_i[BIT_USE];
   assign rights = base_i[RW-1:0] & ovl_i[RW-1:0];

   always_comb begin
      need = '0;
      unique case (kind_i)
         ACC_READ:  need[BIT_RD] = 1'b1;
         ACC_WRITE: need[BIT_WR] = 1'b1;
         ACC_EXEC:  need[BIT_EX] = 1'b1;
         default:   need = '0;
      endcase
   end

   always_comb begin
      perm_o  = '0;
      fault_o = 1'b0;
      if (valid_i) begin
         if (usable) perm_o = {1'b1, rights};
         fault_o = (kind_i == ACC_RSVD) || !usable || ((rights & need) == '0);
      end
   end

endmodule

// File: rtl/ipr_resolver.sv
module ipr_resolver
   import ipr_pkg::*;
#(
   parameter int unsigned IDX_W     = 4,
   parameter int unsigned FIELD_W   = 4,
   parameter bit          SPLIT_OVL = 1'b1,
   localparam int unsigned ARR_W    = (1 << IDX_W) * FIELD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [1:0]         cfg_addr,
   input  logic [ARR_W-1:0]   cfg_data,
   input  logic               req_valid,
   input  logic [IDX_W-1:0]   req_base_idx,
   input  logic [IDX_W-1:0]   req_ovl_idx,
   input  logic [1:0]         req_kind,
   input  logic               req_priv,
   output logic               resp_valid,
   output logic               resp_fault,
   output logic [FIELD_W-1:0] resp_perm
);

   if (FIELD_W != ENT_W) begin : g_bad_field
      $error("ipr_resolver: FIELD_W must be 4");
   end

   logic             q_valid;
   logic [IDX_W-1:0] q_base;
   logic [IDX_W-1:0] q_ovl;
   acc_kind_e        q_kind;
   logic             q_priv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_base  <= '0;
         q_ovl   <= '0;
         q_kind  <= ACC_READ;
         q_priv  <= 1'b0;
      end else begin
         q_valid <= req_valid;
         if (req_valid) begin
            q_base <= req_base_idx;
            q_ovl  <= req_ovl_idx;
            q_kind <= acc_kind_e'(req_kind);
            q_priv <= req_priv;
         end
      end
   end

   cfg_sel_e cfg_sel;
   assign cfg_sel = cfg_sel_e'(cfg_addr);

   logic we_base, we_pr, we_un;
   assign we_base = cfg_we && (cfg_sel == SEL_BASE);
   assign we_pr   = cfg_we && (cfg_sel == SEL_OVL_PR);
   assign we_un   = cfg_we && (cfg_sel == SEL_OVL_UN);

   logic [FIELD_W-1:0] base_ent;
   logic [FIELD_W-1:0] ovl_ent;

   ipr_array_reg #(.IDX_W(IDX_W), .FIELD_W(FIELD_W)) u_base (
      .clk(clk), .rst_n(rst_n), .wr_en(we_base), .wr_data(cfg_data),
      .rd_idx(q_base), .rd_entry(base_ent)
   );

   if (SPLIT_OVL) begin : g_split
      logic [FIELD_W-1:0] pr_ent, un_ent;
      ipr_array_reg #(.IDX_W(IDX_W), .FIELD_W(FIELD_W)) u_ovl_pr (
         .clk(clk), .rst_n(rst_n), .wr_en(we_pr), .wr_data(cfg_data),
         .rd_idx(q_ovl), .rd_entry(pr_ent)
      );
      ipr_array_reg #(.IDX_W(IDX_W), .FIELD_W(FIELD_W)) u_ovl_un (
         .clk(clk), .rst_n(rst_n), .wr_en(we_un), .wr_data(cfg_data),
         .rd_idx(q_ovl), .rd_entry(un_ent)
      );
      assign ovl_ent = q_priv ? pr_ent : un_ent;
   end else begin : g_shared
      ipr_array_reg #(.IDX_W(IDX_W), .FIELD_W(FIELD_W)) u_ovl (
         .clk(clk), .rst_n(rst_n), .wr_en(we_pr | we_un), .wr_data(cfg_data),
         .rd_idx(q_ovl), .rd_entry(ovl_ent)
      );
   end

   ipr_combine #(.FIELD_W(FIELD_W)) u_comb (
      .valid_i(q_valid), .base_i(base_ent), .ovl_i(ovl_ent), .kind_i(q_kind),
      .perm_o(resp_perm), .fault_o(resp_fault)
   );

   assign resp_valid = q_valid;

   // R9: a request shows up as a result one edge later
   p_resp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> resp_valid);

   // R9: no result means no fault and no rights
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !resp_valid |-> (!resp_fault && resp_perm == '0));

   // R3: resolved rights are a subset of both selected entries
   p_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> ((resp_perm[FIELD_W-2:0] & ~(base_ent[FIELD_W-2:0] & ovl_ent[FIELD_W-2:0])) == '0));

   // R4: an unusable entry on either side always faults
   p_unusable_faults_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !(base_ent[BIT_USE] && ovl_ent[BIT_USE])) |-> (resp_fault && resp_perm == '0));

   // R7: the reserved access kind always faults
   p_rsvd_faults_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && q_kind == ACC_RSVD) |-> resp_fault);

endmodule

// File: tb/ipr_resolver_tb.sv
module ipr_resolver_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [63:0] cfg_data = '0;
   logic        req_valid = 1'b0;
   logic [3:0]  req_base_idx = '0;
   logic [3:0]  req_ovl_idx = '0;
   logic [1:0]  req_kind = '0;
   logic        req_priv = 1'b0;
   logic        resp_valid;
   logic        resp_fault;
   logic [3:0]  resp_perm;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ipr_resolver u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_data(cfg_data), .req_valid(req_valid), .req_base_idx(req_base_idx),
      .req_ovl_idx(req_ovl_idx), .req_kind(req_kind), .req_priv(req_priv),
      .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_perm(resp_perm)
   );

   // {base, ovl, kind, priv, exp_fault, exp_perm}
   localparam logic [15:0] VEC [12] = '{
      {4'd1, 4'd0, 2'd0, 1'b1, 1'b0, 4'hF},  // R3 R5 full rights, read ok
      {4'd1, 4'd1, 2'd0, 1'b1, 1'b1, 4'hA},  // R6 overlay leaves write only
      {4'd1, 4'd1, 2'd1, 1'b1, 1'b0, 4'hA},  // R6 write allowed
      {4'd2, 4'd0, 2'd1, 1'b1, 1'b1, 4'h9},  // R3 base caps at read
      {4'd1, 4'd2, 2'd0, 1'b1, 1'b1, 4'h0},  // R4 overlay unusable
      {4'd0, 4'd0, 2'd0, 1'b1, 1'b1, 4'h0},  // R4 base unusable
      {4'd1, 4'd0, 2'd0, 1'b0, 1'b0, 4'h9},  // R5 unprivileged overlay
      {4'd1, 4'd1, 2'd2, 1'b0, 1'b0, 4'hC},  // R6 execute ok
      {4'd3, 4'd1, 2'd2, 1'b0, 1'b1, 4'h8},  // R3 empty intersection
      {4'd3, 4'd0, 2'd1, 1'b0, 1'b1, 4'h9},  // R5 unpriv narrows write
      {4'd1, 4'd0, 2'd3, 1'b1, 1'b1, 4'hF},  // R7 reserved kind
      {4'd3, 4'd0, 2'd1, 1'b1, 1'b0, 4'hB}   // R2 entry 3 bit layout
   };

   task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got valid/fault/perm=%b expected %b", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [63:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rq(input logic [3:0] b, input logic [3:0] o, input logic [1:0] k, input logic p);
      req_valid = 1'b1; req_base_idx = b; req_ovl_idx = o; req_kind = k; req_priv = p;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", {resp_valid, resp_fault, resp_perm}, 6'b0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: empty arrays grant nothing
      rq(4'd5, 4'd5, 2'd0, 1'b1);
      chk("R1", {resp_valid, resp_fault, resp_perm}, {2'b11, 4'h0});

      wr(2'd0, 64'h0000_0000_0000_B9F0);
      wr(2'd1, 64'h0000_0000_0000_07AF);
      wr(2'd2, 64'h0000_0000_0000_00C9);

      for (int i = 0; i < 12; i++) begin
         rq(VEC[i][15:12], VEC[i][11:8], VEC[i][7:6], VEC[i][5]);
         chk($sformatf("R3/R4/R5/R6 vec %0d", i), {resp_valid, resp_fault, resp_perm},
             {1'b1, VEC[i][4], VEC[i][3:0]});
      end

      // R9: idle cycle
      @(negedge clk);
      chk("R9", {resp_valid, resp_fault, resp_perm}, 6'b0);

      // R8: address 3 changes nothing
      wr(2'd3, 64'h0);
      rq(4'd1, 4'd0, 2'd0, 1'b1);
      chk("R8", {resp_valid, resp_fault, resp_perm}, {2'b10, 4'hF});

      // R8: rewrite privileged overlay entry 0 to read only, same edge as request
      cfg_we = 1'b1; cfg_addr = 2'd1; cfg_data = 64'h0000_0000_0000_07A9;
      rq(4'd1, 4'd0, 2'd1, 1'b1);
      cfg_we = 1'b0;
      chk("R8", {resp_valid, resp_fault, resp_perm}, {2'b11, 4'h9});

      // R5: unprivileged overlay untouched by that write
      rq(4'd1, 4'd1, 2'd2, 1'b0);
      chk("R5", {resp_valid, resp_fault, resp_perm}, {2'b10, 4'hC});

      // R4: base entry 15 usable but overlay entry 15 empty
      wr(2'd0, 64'hF000_0000_0000_B9F0);
      rq(4'd15, 4'd15, 2'd0, 1'b0);
      chk("R4", {resp_valid, resp_fault, resp_perm}, {2'b11, 4'h0});

      // R2: entry 15 position in the word
      wr(2'd2, 64'hF000_0000_0000_00C9);
      rq(4'd15, 4'd15, 2'd2, 1'b0);
      chk("R2", {resp_valid, resp_fault, resp_perm}, {2'b10, 4'hF});

      // R1: reset clears arrays again
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rq(4'd1, 4'd0, 2'd0, 1'b1);
      chk("R1", {resp_valid, resp_fault, resp_perm}, {2'b11, 4'h0});

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule